// File: doc/BRIEF.md
# Signed 64-bit Multiply-High Unit

This block computes the upper 64 bits of the 128-bit product of two 64-bit operands. The operands can be treated as two's-complement signed values or as unsigned values. In signed mode, each negative operand is first replaced by its magnitude. The unit then multiplies the two magnitudes as unsigned numbers and restores the sign of the product at the end.

The unsigned product is built from four 32x32 partial products. The two middle partial products are summed. The carry out of that sum enters the upper half 32 bit positions above the middle sum's own contribution. A second carry comes from adding the low 32 bits of the middle sum to the upper 32 bits of the low-by-low product, and it also feeds the upper half.

Sign restoration negates the 128-bit magnitude product while keeping only its upper half. The upper half is inverted bitwise. A one is added to it only when the low 64 bits of the magnitude product are all zero.

A request is a one-cycle `start` with the operands and the mode. The result appears three cycles later with a one-cycle `done`, and it is held until the next result.

Top module: `mulhi_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `done` is 0 and `result` is 0.
- R2: With `signed_mode`=1, `result` equals bits 127:64 of the signed 128-bit product of `op_a` and `op_b`.
- R3: With `signed_mode`=0, `result` equals bits 127:64 of the unsigned 128-bit product, and no sign correction is applied.
- R4: `start` is sampled on a rising edge while the unit is idle. `done` goes high exactly 4 rising edges later, counting the sampling edge as the first, and stays high for exactly one cycle.
- R5: A `start` that arrives while a computation is in flight is ignored. The pending result still belongs to the first operands, and no extra `done` pulse follows.
- R6: An operand of -2^63 in signed mode is handled as magnitude 2^63. Expected results: (-2^63)x(-2^63) gives 0x4000000000000000; (-2^63)x1 gives all ones; (-2^63)x(-1) gives 0.
- R7: A negative product whose low 64 bits are zero gets the plus-one correction. For example, (-2^32)x(2^32) gives all ones. A negative product with a nonzero low half does not; for example, (-1)x1 gives all ones.
- R8: Carries from the middle-product sum and from the low-half accumulation reach the upper half. For example, unsigned all-ones x all-ones gives 0xFFFFFFFFFFFFFFFE.
- R9: `result` changes only in a cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply; sampled only while idle |
| signed_mode | input | 1 | 1: signed operands; 0: unsigned operands |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 64 | Upper 64 bits of the product |

## Verification
The in-module properties check the following on every cycle:
- the single-cycle `done` pulse, and that it always follows the final stage;
- that the latched magnitudes stay frozen while a computation is in flight;
- that `result` changes only together with `done`;
- that the final stage passes the unsigned upper half through unchanged when no negation is pending, and applies a plain inversion when the low half is nonzero.

The numeric correctness of the assembled upper half cannot be expressed as a simple property. This covers carry propagation, the most-negative operand, and the zero-low-half plus-one case. Only the bench's scenarios show it: directed corner operands and seeded random operands in both modes, compared against a full 128-bit product computed in the bench.

// File: rtl/mulhi_unit.sv
module mulhi_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int H = W / 2;

  typedef enum logic [1:0] {IDLE, MUL, SUM, FIX} st_t;
  st_t st;

  logic [W-1:0] mag_a, mag_b;
  logic         neg;
  logic [W-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
  logic [W-1:0] hi_u;
  logic         lo_zero;

  logic [W-1:0] a_lo, a_hi, b_lo, b_hi;
  assign a_lo = {{H{1'b0}}, mag_a[H-1:0]};
  assign a_hi = {{H{1'b0}}, mag_a[W-1:H]};
  assign b_lo = {{H{1'b0}}, mag_b[H-1:0]};
  assign b_hi = {{H{1'b0}}, mag_b[W-1:H]};

  logic [W:0]   mid;
  logic [H:0]   low_acc;
  logic [W-1:0] hi_sum, lo_word;
  assign mid     = {1'b0, pp_lh} + {1'b0, pp_hl};
  assign low_acc = {1'b0, pp_ll[W-1:H]} + {1'b0, mid[H-1:0]};
  assign hi_sum  = pp_hh
                 + {{H{1'b0}}, mid[W-1:H]}
                 + {{(H-1){1'b0}}, mid[W], {H{1'b0}}}
                 + {{(W-1){1'b0}}, low_acc[H]};
  assign lo_word = {low_acc[H-1:0], pp_ll[H-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      done    <= 1'b0;
      result  <= '0;
      mag_a   <= '0;
      mag_b   <= '0;
      neg     <= 1'b0;
      pp_ll   <= '0;
      pp_lh   <= '0;
      pp_hl   <= '0;
      pp_hh   <= '0;
      hi_u    <= '0;
      lo_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          mag_a <= (signed_mode && op_a[W-1]) ? -op_a : op_a;
          mag_b <= (signed_mode && op_b[W-1]) ? -op_b : op_b;
          neg   <= signed_mode && (op_a[W-1] ^ op_b[W-1]);
          st    <= MUL;
        end
        MUL: begin
          pp_ll <= a_lo * b_lo;
          pp_lh <= a_lo * b_hi;
          pp_hl <= a_hi * b_lo;
          pp_hh <= a_hi * b_hi;
          st    <= SUM;
        end
        SUM: begin
          hi_u    <= hi_sum;
          lo_zero <= (lo_word == '0);
          st      <= FIX;
        end
        default: begin
          result <= neg ? (~hi_u + {{(W-1){1'b0}}, lo_zero}) : hi_u;
          done   <= 1'b1;
          st     <= IDLE;
        end
      endcase
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_fix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FIX) |=> done);
  p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE) |=> ($stable(mag_a) && $stable(mag_b)));
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  p_no_negate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FIX && !neg) |=> (result == $past(hi_u)));
  p_invert_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FIX && neg && !lo_zero) |=> (result == ~$past(hi_u)));
endmodule

// File: tb/sim_mulhi_unit.sv
module sim_mulhi_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        done;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;

  mulhi_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
                 .op_a(op_a), .op_b(op_b), .done(done), .result(result));

  always #10 clk = ~clk;

  function automatic logic [63:0] ref_hi(input logic [63:0] a, input logic [63:0] b, input logic s);
    logic [127:0] p;
    if (s) p = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
    else   p = {64'd0, a} * {64'd0, b};
    return p[127:64];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [63:0] a, input logic [63:0] b,
                     input logic s, input bit busy_poke);
    int cnt;
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; signed_mode = s;
    @(negedge clk);
    cnt = 1;
    if (busy_poke) begin
      op_a = ~a; op_b = b + 64'd7; signed_mode = ~s;
    end else start = 1'b0;
    while (!done && cnt < 50) begin
      @(negedge clk);
      cnt++;
      if (cnt == 3) start = 1'b0;
    end
    start = 1'b0;
    check({req, " value"}, result, ref_hi(a, b, s));
    if (req == "R4" || busy_poke) check("R4 latency", 64'(cnt), 64'd4);
    @(negedge clk);
    check("R4 single-cycle done", {63'd0, done}, 64'd0);
    if (busy_poke) begin
      repeat (4) @(negedge clk);
      check("R5 no extra done", {63'd0, done}, 64'd0);
      check("R9 result held", result, ref_hi(a, b, s));
    end
  endtask

  initial begin
    int seed;
    seed = 32'h1234abcd;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 done in reset", {63'd0, done}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", {63'd0, done}, 64'd0);
    check("R1 result after reset", result, 64'd0);

    run("R4", 64'd3, 64'd5, 1'b1, 1'b0);
    run("R2", -64'sd1, 64'd1, 1'b1, 1'b0);
    run("R2", 64'h1234_5678_9abc_def0, -64'sd987654321, 1'b1, 1'b0);
    run("R3", -64'sd1, 64'd2, 1'b0, 1'b0);
    run("R6", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b0);
    check("R6 min*min", result, 64'h4000_0000_0000_0000);
    run("R6", 64'h8000_0000_0000_0000, 64'd1, 1'b1, 1'b0);
    check("R6 min*1", result, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R6", 64'h8000_0000_0000_0000, -64'sd1, 1'b1, 1'b0);
    check("R6 min*-1", result, 64'd0);
    run("R7", -64'sd4294967296, 64'd4294967296, 1'b1, 1'b0);
    check("R7 zero low half", result, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R7", -64'sd1, 64'd1, 1'b1, 1'b0);
    check("R7 nonzero low half", result, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R8", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    check("R8 all ones", result, 64'hFFFF_FFFF_FFFF_FFFE);
    run("R8", 64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    run("R5", 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 1'b1, 1'b1);

    for (int i = 0; i < 300; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if (i % 7 == 0) ra[31:0] = '0;
      if (i % 11 == 0) rb = -rb;
      run((i % 2) ? "R2" : "R3", ra, rb, i[0], 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule